// File: doc/BRIEF.md
# Read-Buffer Hit Monitor

This block watches the read requests that reach a memory controller's read buffer and keeps hit statistics for them. Each read arrives as a bus tenure. A tenure opens with a start strobe that carries the requesting master. One or more data phases follow, and an end strobe closes it. The buffer reports whether the request hit at the first data phase. Counting happens once per tenure and never once per data word. A burst that moves four words and hits adds one, exactly as a single-word hit does.

There are two independent counting resources. Each resource has an enable, a master selector and a clear. Each keeps a hit count and a total request count, so software can compute the hit/miss ratio as hits against total minus hits. A small word-addressed register port holds the controls and returns the counts.

Top module: `rbuf_hit_monitor`

## Requirements
- R1: After reset every control word reads 0, so every resource is disabled with selector 0, and every hit and total count reads 0.
- R2: A tenure of two, three or four data phases whose first phase hits adds exactly 1 to the hit count and 1 to the total count of each matching enabled resource.
- R3: Separate single-phase tenures are each counted, so four single-word hits add 4 to the hit count.
- R4: The hit/miss outcome is taken from the first data phase of the tenure. The hit flag on later phases of the same tenure has no effect.
- R5: A tenure whose first phase misses adds 1 to the total count and leaves the hit count unchanged.
- R6: The selector field is control bits [2:1], coded 0 = CPU, 1 = PCI host bridge, 2 = DMA, 3 = no master. A resource ignores tenures from any master other than the selected one.
- R7: Control bit 0 is the enable. A disabled resource leaves both of its counts unchanged.
- R8: Counts saturate at their all-ones value and do not wrap.
- R9: Writing 1 to control bit 3 zeroes that resource's hit and total counts. The bit reads 0. If a counted tenure completes in the same cycle, the clear takes priority and both counts read 0 afterwards.
- R10: The two resources count independently. A tenure that matches both is counted by both.
- R11: A tenure that ends without any data phase is not counted.
- R12: Register map (word addresses): 0 = resource 0 control, 1 = resource 1 control, 2 = resource 0 hits, 3 = resource 0 total, 4 = resource 1 hits, 5 = resource 1 total. Reads are combinational from the address, and counts are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | First cycle of a read tenure |
| req_src | input | 2 | Requesting master, valid with req_start |
| data_valid | input | 1 | A data phase of the open tenure |
| data_hit | input | 1 | Read-buffer hit flag for the data phase |
| tenure_end | input | 1 | Last cycle of the tenure |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The hardest case to reach is a clear that lands in the same clock edge as a completed tenure's count pulse. The pulse is registered one cycle behind the tenure's end strobe. To make the two coincide, the stimulus issues a one-cycle tenure and, on the very next cycle, the clearing control write. Saturation is reached with a narrowed count width and a long run of single-word hits. Changes to the first-phase outcome are covered by bursts whose later phases carry the opposite hit flag.

// File: rtl/hitmon_pkg.sv
// Shared types for the read-buffer hit monitor.
// Assumes masters are coded in two bits; code 3 selects no master.
package hitmon_pkg;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'd0,
        SRC_PCIB = 2'd1,
        SRC_DMA  = 2'd2,
        SRC_NONE = 2'd3
    } master_e;

    // One completed tenure, presented for a single cycle
    typedef struct packed {
        logic    valid;
        logic    hit;
        master_e src;
    } outcome_t;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEL_LSB = 1;
    localparam int CTRL_SEL_W   = 2;
    localparam int CTRL_CLR_BIT = 3;

endpackage

// File: rtl/hitmon_tenure_track.sv
// Follows one bus tenure at a time and reduces it to a single outcome pulse.
// The hit flag is captured at the first data phase and held until the end strobe.
// Assumes tenures do not overlap; a new start restarts tracking.
// A tenure with no data phase produces no pulse.
module hitmon_tenure_track
    import hitmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_start,
    input  logic [1:0] req_src,
    input  logic       data_valid,
    input  logic       data_hit,
    input  logic       tenure_end,
    output outcome_t   result
);

    logic    active_q;
    logic    seen_q;
    logic    hit_q;
    master_e src_q;

    logic    active_eff;
    logic    seen_prev;
    logic    seen_eff;
    logic    hit_eff;
    master_e src_eff;

    // Merge the registered tenure state with this cycle's strobes
    always_comb begin
        active_eff = active_q | req_start;
        src_eff    = req_start ? master_e'(req_src) : src_q;
        seen_prev  = req_start ? 1'b0 : seen_q;
        seen_eff   = seen_prev | data_valid;
        hit_eff    = seen_prev ? hit_q : data_hit;
    end

    // Track tenure state and latch the first-phase outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            seen_q   <= 1'b0;
            hit_q    <= 1'b0;
            src_q    <= SRC_CPU;
        end else if (tenure_end) begin
            active_q <= 1'b0;
            seen_q   <= 1'b0;
            hit_q    <= 1'b0;
        end else if (active_eff) begin
            active_q <= 1'b1;
            src_q    <= src_eff;
            seen_q   <= seen_eff;
            hit_q    <= seen_eff ? hit_eff : 1'b0;
        end
    end

    // Emit one outcome pulse per tenure that moved data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else begin
            result.valid <= tenure_end & active_eff & seen_eff;
            result.hit   <= hit_eff;
            result.src   <= src_eff;
        end
    end

    // Once captured, the outcome stays put while the tenure continues
    assert_latched_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && seen_q && !req_start && !tenure_end) |=> (hit_q == $past(hit_q)));

    // An end strobe with no data phase seen yields no outcome
    assert_no_data_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tenure_end && !data_valid && (!seen_q || req_start)) |=> !result.valid);

endmodule

// File: rtl/hitmon_sat_counter.sv
// Saturating up-counter with a synchronous clear that overrides increment.
// Assumes at most one increment per cycle.
module hitmon_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up, stick at the top, clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc && value != CNT_MAX) begin
            value <= value + 1'b1;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (value == CNT_MAX && !clr) |=> (value == CNT_MAX));

    assert_clear_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0));

endmodule

// File: rtl/hitmon_resource.sv
// One counting resource: filters outcomes by master and enable, and counts
// requests and hits. Assumes the outcome pulse lasts one cycle per tenure.
module hitmon_resource
    import hitmon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       sel,
    input  logic             clr,
    input  outcome_t         ev,
    output logic [CNT_W-1:0] hits,
    output logic [CNT_W-1:0] total
);

    logic match;

    // Decide whether this outcome belongs to the resource
    always_comb begin
        match = ev.valid && en && (ev.src == master_e'(sel));
    end

    hitmon_sat_counter #(.CNT_W(CNT_W)) u_total (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (match),
        .value (total)
    );

    hitmon_sat_counter #(.CNT_W(CNT_W)) u_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (match && ev.hit),
        .value (hits)
    );

    assert_hits_within_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hits <= total);

    assert_disabled_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(total));

    assert_other_master_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.src != master_e'(sel) && !clr) |=> ($stable(total) && $stable(hits)));

endmodule

// File: rtl/hitmon_regs.sv
// Register port: per-resource control words and read access to counts.
// Control layout: bit 0 enable, bits 2:1 master select, bit 3 clear (write-1, reads 0).
// Assumes DATA_W >= CNT_W and the address space covers 3*NUM_RES words.
module hitmon_regs
    import hitmon_pkg::*;
#(
    parameter int NUM_RES = 2,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    input  logic [NUM_RES-1:0][CNT_W-1:0]   hits,
    input  logic [NUM_RES-1:0][CNT_W-1:0]   totals,
    output logic [NUM_RES-1:0]              en,
    output logic [NUM_RES-1:0][1:0]         sel,
    output logic [NUM_RES-1:0]              clr,
    output logic [DATA_W-1:0]               rdata
);

    localparam int CNT_BASE = NUM_RES;

    // Hold the control fields written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= '0;
            sel <= '0;
        end else begin
            for (int i = 0; i < NUM_RES; i++) begin
                if (reg_wr && reg_addr == ADDR_W'(i)) begin
                    en[i]  <= reg_wdata[CTRL_EN_BIT];
                    sel[i] <= reg_wdata[CTRL_SEL_LSB +: CTRL_SEL_W];
                end
            end
        end
    end

    // Decode clear strobes straight from the write so they meet same-cycle events
    always_comb begin
        clr = '0;
        for (int i = 0; i < NUM_RES; i++) begin
            clr[i] = reg_wr && (reg_addr == ADDR_W'(i)) && reg_wdata[CTRL_CLR_BIT];
        end
    end

    // Select the read word from the address
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_RES; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                rdata[CTRL_EN_BIT]                    = en[i];
                rdata[CTRL_SEL_LSB +: CTRL_SEL_W]     = sel[i];
            end
            if (reg_addr == ADDR_W'(CNT_BASE + 2 * i)) begin
                rdata[CNT_W-1:0] = hits[i];
            end
            if (reg_addr == ADDR_W'(CNT_BASE + 2 * i + 1)) begin
                rdata[CNT_W-1:0] = totals[i];
            end
        end
    end

    assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < ADDR_W'(NUM_RES)) |-> (rdata[CTRL_CLR_BIT] == 1'b0));

endmodule

// File: rtl/rbuf_hit_monitor.sv
// Top of the read-buffer hit monitor: one tenure tracker feeding NUM_RES
// counting resources, with a register port for control and count readback.
// Assumes tenures arrive one at a time on a single event interface.
module rbuf_hit_monitor
    import hitmon_pkg::*;
#(
    parameter int NUM_RES = 2,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [1:0]        req_src,
    input  logic              data_valid,
    input  logic              data_hit,
    input  logic              tenure_end,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    outcome_t                         outcome;
    logic [NUM_RES-1:0]               res_en;
    logic [NUM_RES-1:0][1:0]          res_sel;
    logic [NUM_RES-1:0]               res_clr;
    logic [NUM_RES-1:0][CNT_W-1:0]    res_hits;
    logic [NUM_RES-1:0][CNT_W-1:0]    res_total;

    hitmon_tenure_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_start  (req_start),
        .req_src    (req_src),
        .data_valid (data_valid),
        .data_hit   (data_hit),
        .tenure_end (tenure_end),
        .result     (outcome)
    );

    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
        hitmon_resource #(.CNT_W(CNT_W)) u_res (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (res_en[g]),
            .sel   (res_sel[g]),
            .clr   (res_clr[g]),
            .ev    (outcome),
            .hits  (res_hits[g]),
            .total (res_total[g])
        );
    end

    hitmon_regs #(
        .NUM_RES (NUM_RES),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hits      (res_hits),
        .totals    (res_total),
        .en        (res_en),
        .sel       (res_sel),
        .clr       (res_clr),
        .rdata     (reg_rdata)
    );

endmodule

// File: tb/rbuf_hit_monitor_tb_top.sv
`timescale 1ns/1ps
module rbuf_hit_monitor_tb_top;

    localparam int CW   = 6;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [1:0]  req_src = 2'd0;
    logic        data_valid = 1'b0;
    logic        data_hit = 1'b0;
    logic        tenure_end = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    int exp_hit [2];
    int exp_tot [2];
    bit cfg_en  [2];
    int cfg_sel [2];

    always #2.5 clk = ~clk;

    rbuf_hit_monitor #(.CNT_W(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_start  (req_start),
        .req_src    (req_src),
        .data_valid (data_valid),
        .data_hit   (data_hit),
        .tenure_end (tenure_end),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    typedef struct packed {
        logic [1:0] src;
        logic [2:0] beats;
        logic       first_hit;
        logic       later_hit;
    } vec_t;

    // src, data phases, first-phase hit, later-phase hit
    localparam vec_t VECS [12] = '{
        '{2'd0, 3'd4, 1'b1, 1'b0},
        '{2'd0, 3'd1, 1'b1, 1'b0},
        '{2'd0, 3'd1, 1'b1, 1'b0},
        '{2'd0, 3'd2, 1'b0, 1'b1},
        '{2'd1, 3'd3, 1'b1, 1'b1},
        '{2'd2, 3'd1, 1'b1, 1'b0},
        '{2'd2, 3'd4, 1'b0, 1'b1},
        '{2'd0, 3'd0, 1'b1, 1'b1},
        '{2'd2, 3'd3, 1'b1, 1'b0},
        '{2'd3, 3'd2, 1'b1, 1'b1},
        '{2'd0, 3'd3, 1'b1, 1'b1},
        '{2'd1, 3'd1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic reg_write(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output int v);
        @(negedge clk);
        reg_addr = a[2:0];
        #1 v = int'(reg_rdata);
    endtask

    task automatic configure(input int r, input bit e, input int s);
        cfg_en[r] = e; cfg_sel[r] = s;
        reg_write(r, (s << 1) | int'(e));
    endtask

    // Reference model of the counting rule
    task automatic model(input int s, input int beats, input bit fh);
        for (int r = 0; r < 2; r++) begin
            if (beats > 0 && cfg_en[r] && cfg_sel[r] == s) begin
                if (exp_tot[r] < MAXV) exp_tot[r]++;
                if (fh && exp_hit[r] < MAXV) exp_hit[r]++;
            end
        end
    endtask

    task automatic run_tenure(input int s, input int beats, input bit fh, input bit lh);
        @(negedge clk);
        req_start = 1'b1; req_src = s[1:0];
        if (beats == 0) begin
            @(negedge clk);
            req_start = 1'b0; tenure_end = 1'b1;
        end else begin
            for (int b = 0; b < beats; b++) begin
                if (b > 0) begin
                    @(negedge clk);
                    req_start = 1'b0;
                end
                data_valid = 1'b1;
                data_hit   = (b == 0) ? fh : lh;
                tenure_end = (b == beats - 1);
            end
        end
        @(negedge clk);
        req_start = 1'b0; data_valid = 1'b0; data_hit = 1'b0; tenure_end = 1'b0;
        repeat (2) @(negedge clk);
        model(s, beats, fh);
    endtask

    task automatic check_counts(input string tag);
        int v;
        for (int r = 0; r < 2; r++) begin
            reg_read(2 + 2 * r, v);
            check($sformatf("%s res%0d hits", tag, r), v, exp_hit[r]);
            reg_read(3 + 2 * r, v);
            check($sformatf("%s res%0d total", tag, r), v, exp_tot[r]);
        end
    endtask

    task automatic check_reset_state(input string tag);
        int v;
        for (int a = 0; a < 6; a++) begin
            reg_read(a, v);
            check($sformatf("%s addr%0d", tag, a), v, 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 2; r++) begin
            exp_hit[r] = 0; exp_tot[r] = 0; cfg_en[r] = 1'b0; cfg_sel[r] = 0;
        end
    endtask

    initial begin
        int v;
        do_reset();
        check_reset_state("R1 reset");

        // Table walk: res0 follows the CPU, res1 follows DMA (R2 R3 R4 R5 R6 R11)
        configure(0, 1'b1, 0);
        configure(1, 1'b1, 2);
        reg_read(0, v);
        check("R12 ctrl0 readback", v, 32'h1);
        reg_read(1, v);
        check("R12 ctrl1 readback", v, 32'h5);
        foreach (VECS[i]) begin
            run_tenure(int'(VECS[i].src), int'(VECS[i].beats), VECS[i].first_hit, VECS[i].later_hit);
            check_counts($sformatf("R2/R3/R4/R5/R6/R11 vec%0d", i));
        end

        // R10: both resources on the CPU count the same tenure
        configure(1, 1'b1, 0);
        run_tenure(0, 2, 1'b1, 1'b0);
        check_counts("R10 shared source");

        // R7: disabled resource stays frozen
        configure(0, 1'b0, 0);
        run_tenure(0, 1, 1'b1, 1'b0);
        check_counts("R7 disabled");
        configure(0, 1'b1, 0);

        // R9: clear coinciding with the count pulse of a one-cycle tenure
        @(negedge clk);
        req_start = 1'b1; req_src = 2'd0; data_valid = 1'b1; data_hit = 1'b1; tenure_end = 1'b1;
        @(negedge clk);
        req_start = 1'b0; data_valid = 1'b0; data_hit = 1'b0; tenure_end = 1'b0;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h9;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        exp_hit[0] = 0; exp_tot[0] = 0;
        if (exp_tot[1] < MAXV) exp_tot[1]++;
        if (exp_hit[1] < MAXV) exp_hit[1]++;
        check_counts("R9 clear priority");
        reg_read(0, v);
        check("R9 clear bit reads zero", v, 32'h1);

        // R8: drive past the top of the count range
        configure(1, 1'b1, 3);
        for (int k = 0; k < MAXV + 6; k++) begin
            run_tenure(0, 1, 1'b1, 1'b0);
        end
        check_counts("R8 saturation");
        run_tenure(0, 1, 1'b0, 1'b0);
        check_counts("R8 saturated miss");

        // R1: reset in mid-run returns everything to zero
        do_reset();
        check_reset_state("R1 reset after use");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule